// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block sequences the transfers of one external bus access to a single chip-select region. An access holds one or more transfers. It may be a single transfer, a burst, or a non-burst access that needs several transfers. Each transfer opens with a one-cycle start phase and then waits for termination. Termination comes from one of two sources. The first is an automatic acknowledge that fires after a programmed number of wait states. The second is an acknowledge driven by the external device.

Two conditions abort the access. One is an external error input. The other is an internal bus monitor that counts the cycles of each transfer and raises the same error when no acknowledge arrives in time. On abort the access ends at once and every remaining transfer is dropped. The block then reports completion with an error flag and the number of transfers that finished. Address decoding, data steering and port sizing belong to neighbouring logic.

Top module: `busTermCtl`

## Requirements
- R1: A request (`reqValid` high) is taken only while the block is idle (`busy` low). The transfer count, wait-state field, auto-acknowledge enable, monitor enable and monitor timeout are captured at that edge. The access then runs `reqCount + 1` transfers whatever those inputs do later.
- R2: Each transfer starts with exactly one cycle in which `xferStart` is high. Wait-phase cycles follow. Between the acknowledge of one transfer and the start of the next there is exactly one idle cycle.
- R3: When auto-acknowledge is enabled, a transfer is acknowledged in wait-phase cycle number `waitStates`, counting the first wait cycle as 0. `xferAck` is high in that cycle.
- R4: `extAck` high in any wait-phase cycle acknowledges the transfer in that cycle.
- R5: `extErr` high in a wait-phase cycle aborts the access at the next edge. No further `xferStart` occurs, and the remaining transfers are skipped for single, burst and multi-transfer accesses alike.
- R6: When an error and an acknowledge occur in the same wait-phase cycle, the error wins. `xferAck` stays low and the transfer is not counted.
- R7: When the monitor is enabled, its count restarts at every transfer. An error is raised in wait-phase cycle number `monTimeout` if no acknowledge occurs in that cycle, and that error has the same effect as `extErr`. An acknowledge in that same cycle wins.
- R8: An access ends with `accDone` high for exactly one cycle, after which the block is idle. `accErr` is high with `accDone` only if the access was aborted.
- R9: While `accDone` is high, `doneCount` equals the number of acknowledged transfers. That value holds until the next request is taken.
- R10: After reset, `busy`, `xferStart`, `xferAck`, `accDone` and `accErr` are low and `doneCount` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request |
| reqCount | input | CNT_W | Transfers in the access minus one |
| waitStates | input | WS_W | Wait states before automatic acknowledge |
| autoAckEn | input | 1 | Enable automatic acknowledge |
| monEn | input | 1 | Enable the bus monitor |
| monTimeout | input | MON_W | Wait-phase cycle in which the monitor fires |
| extAck | input | 1 | External transfer acknowledge |
| extErr | input | 1 | External transfer error |
| busy | output | 1 | Access in progress |
| xferStart | output | 1 | Start phase of a transfer |
| xferAck | output | 1 | Transfer acknowledged in this cycle |
| accDone | output | 1 | Access complete pulse |
| accErr | output | 1 | Access was aborted, valid with accDone |
| doneCount | output | CNT_W+1 | Transfers completed |

## Verification
The bench sweeps wait states against monitor timeouts and transfer counts. This exposes a monitor that is not restarted per transfer, because such a monitor aborts long multi-transfer accesses that should pass. The sweep also hits the tie where the auto-acknowledge and the timeout fall in the same cycle, which a design with the wrong priority would report as an error. External errors are placed on every transfer position and combined with a simultaneous acknowledge. A design that finishes the current burst, counts the errored transfer, or lets the acknowledge win would show a wrong `doneCount` or extra start strobes. Request fields are changed mid-access with `reqValid` held high, which catches a design that re-samples its configuration or accepts a request outside idle.

// File: rtl/busTermPkg.sv
package busTermPkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_WAIT  = 3'd2,
    ST_NEXT  = 3'd3,
    ST_END   = 3'd4
  } termState_t;

  typedef struct packed {
    logic accept;
    logic xferBegin;
    logic tick;
    logic ackTake;
    logic setErr;
  } dpStrobe_t;

endpackage

// File: rtl/busTermDatapath.sv
module busTermDatapath
  import busTermPkg::*;
#(
  parameter int CNT_W = 3,
  parameter int WS_W = 4,
  parameter int MON_W = 6,
  parameter bit HAS_MONITOR = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [WS_W-1:0]  waitStates,
  input  logic             autoAckEn,
  input  logic             monEn,
  input  logic [MON_W-1:0] monTimeout,
  output logic             autoHit,
  output logic             monHit,
  output logic             lastXfer,
  output logic             errFlag,
  output logic [CNT_W:0]   doneCount
);

  localparam int XFER_W = CNT_W + 1;

  logic [CNT_W-1:0]  cntLat;
  logic [WS_W-1:0]   wsLat;
  logic              autoLat;
  logic [WS_W-1:0]   waitCnt;
  logic [XFER_W-1:0] xferCnt;
  logic              errLat;

  // Configuration is frozen when the access is taken
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLat  <= '0;
      wsLat   <= '0;
      autoLat <= 1'b0;
    end else if (strobe.accept) begin
      cntLat  <= reqCount;
      wsLat   <= waitStates;
      autoLat <= autoAckEn;
    end
  end

  // Wait-state counter, restarted in each start phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.xferBegin) begin
      waitCnt <= '0;
    end else if (strobe.tick) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign autoHit = autoLat && (waitCnt == wsLat);

  // Completed-transfer counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferCnt <= '0;
    end else if (strobe.accept) begin
      xferCnt <= '0;
    end else if (strobe.ackTake) begin
      xferCnt <= xferCnt + 1'b1;
    end
  end

  assign lastXfer  = (xferCnt == {1'b0, cntLat});
  assign doneCount = xferCnt;

  // Abort flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errLat <= 1'b0;
    end else if (strobe.accept) begin
      errLat <= 1'b0;
    end else if (strobe.setErr) begin
      errLat <= 1'b1;
    end
  end

  assign errFlag = errLat;

  // Bus monitor: optional, selected by parameter
  generate
    if (HAS_MONITOR) begin : g_monitor
      logic [MON_W-1:0] monCnt;
      logic [MON_W-1:0] monToLat;
      logic             monEnLat;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          monToLat <= '0;
          monEnLat <= 1'b0;
        end else if (strobe.accept) begin
          monToLat <= monTimeout;
          monEnLat <= monEn;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          monCnt <= '0;
        end else if (strobe.xferBegin) begin
          monCnt <= '0;
        end else if (strobe.tick && (monCnt != monToLat)) begin
          monCnt <= monCnt + 1'b1;
        end
      end

      assign monHit = monEnLat && (monCnt == monToLat);
    end else begin : g_noMonitor
      logic unusedMon;
      assign unusedMon = monEn ^ (^monTimeout);
      assign monHit    = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/busTermCtrl.sv
module busTermCtrl
  import busTermPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      extAck,
  input  logic      extErr,
  input  logic      autoHit,
  input  logic      monHit,
  input  logic      lastXfer,
  output dpStrobe_t strobe,
  output logic      xferStart,
  output logic      xferAck,
  output logic      accDone,
  output logic      busy
);

  termState_t state, stateNext;
  logic ackNow;
  logic errNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  // Termination sources and their priority
  assign ackNow = extAck || autoHit;
  assign errNow = extErr || (monHit && !ackNow);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.accept = 1'b1;
          stateNext     = ST_START;
        end
      end
      ST_START: begin
        strobe.xferBegin = 1'b1;
        stateNext        = ST_WAIT;
      end
      ST_WAIT: begin
        strobe.tick = 1'b1;
        if (errNow) begin
          strobe.setErr = 1'b1;
          stateNext     = ST_END;
        end else if (ackNow) begin
          strobe.ackTake = 1'b1;
          stateNext      = lastXfer ? ST_END : ST_NEXT;
        end
      end
      ST_NEXT: begin
        stateNext = ST_START;
      end
      ST_END: begin
        stateNext = ST_IDLE;
      end
      default: begin
        stateNext = ST_IDLE;
      end
    endcase
  end

  assign xferStart = (state == ST_START);
  assign xferAck   = strobe.ackTake;
  assign accDone   = (state == ST_END);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/busTermCtl.sv
module busTermCtl
  import busTermPkg::*;
#(
  parameter int CNT_W = 3,
  parameter int WS_W = 4,
  parameter int MON_W = 6,
  parameter bit HAS_MONITOR = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [WS_W-1:0]  waitStates,
  input  logic             autoAckEn,
  input  logic             monEn,
  input  logic [MON_W-1:0] monTimeout,
  input  logic             extAck,
  input  logic             extErr,
  output logic             busy,
  output logic             xferStart,
  output logic             xferAck,
  output logic             accDone,
  output logic             accErr,
  output logic [CNT_W:0]   doneCount
);

  dpStrobe_t strobe;
  logic autoHit;
  logic monHit;
  logic lastXfer;
  logic errFlag;

  busTermCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .extAck    (extAck),
    .extErr    (extErr),
    .autoHit   (autoHit),
    .monHit    (monHit),
    .lastXfer  (lastXfer),
    .strobe    (strobe),
    .xferStart (xferStart),
    .xferAck   (xferAck),
    .accDone   (accDone),
    .busy      (busy)
  );

  busTermDatapath #(
    .CNT_W       (CNT_W),
    .WS_W        (WS_W),
    .MON_W       (MON_W),
    .HAS_MONITOR (HAS_MONITOR)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqCount   (reqCount),
    .waitStates (waitStates),
    .autoAckEn  (autoAckEn),
    .monEn      (monEn),
    .monTimeout (monTimeout),
    .autoHit    (autoHit),
    .monHit     (monHit),
    .lastXfer   (lastXfer),
    .errFlag    (errFlag),
    .doneCount  (doneCount)
  );

  assign accErr = accDone && errFlag;

endmodule

// File: rtl/busTermChecker.sv
module busTermChecker #(
  parameter int CNT_W = 3
) (
  input logic           clk,
  input logic           rstN,
  input logic           reqValid,
  input logic           extErr,
  input logic           busy,
  input logic           xferStart,
  input logic           xferAck,
  input logic           accDone,
  input logic           accErr,
  input logic [CNT_W:0] doneCount
);

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> accDone); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    accDone |=> (!accDone && !busy)); // R8

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> xferStart); // R1

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> (!xferStart && busy)); // R2

  AST_NO_ACK_IN_START: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> !xferAck); // R2

  AST_ERR_BEATS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |-> !extErr); // R6

  AST_ABORT_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !xferStart && extErr) |=> (!xferStart && accDone)); // R5

  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !reqValid) |=> $stable(doneCount)); // R9

endmodule

bind busTermCtl busTermChecker #(.CNT_W(CNT_W)) i_busTermChecker (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .extErr    (extErr),
  .busy      (busy),
  .xferStart (xferStart),
  .xferAck   (xferAck),
  .accDone   (accDone),
  .accErr    (accErr),
  .doneCount (doneCount)
);

// File: tb/test_busTermCtl.sv
module test_busTermCtl;

  localparam int CNT_W = 3;
  localparam int WS_W = 4;
  localparam int MON_W = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [CNT_W-1:0] reqCount = '0;
  logic [WS_W-1:0]  waitStates = '0;
  logic             autoAckEn = 1'b0;
  logic             monEn = 1'b0;
  logic [MON_W-1:0] monTimeout = '0;
  logic             extAck = 1'b0;
  logic             extErr = 1'b0;
  logic             busy, xferStart, xferAck, accDone, accErr;
  logic [CNT_W:0]   doneCount;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  busTermCtl #(.CNT_W(CNT_W), .WS_W(WS_W), .MON_W(MON_W)) i_busTermCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCount(reqCount),
    .waitStates(waitStates), .autoAckEn(autoAckEn), .monEn(monEn),
    .monTimeout(monTimeout), .extAck(extAck), .extErr(extErr),
    .busy(busy), .xferStart(xferStart), .xferAck(xferAck),
    .accDone(accDone), .accErr(accErr), .doneCount(doneCount)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Auto-acknowledge and monitor access; returns observed figures
  task automatic runAuto(input int n, input int ws, input bit mon, input int tmo,
                         input bit holdReq,
                         output int cyc, output int starts, output int acks,
                         output int err, output int cnt);
    @(negedge clk);
    reqValid = 1'b1; reqCount = CNT_W'(n - 1); waitStates = WS_W'(ws);
    autoAckEn = 1'b1; monEn = mon; monTimeout = MON_W'(tmo);
    cyc = 0; starts = 0; acks = 0; err = 0; cnt = 0;
    while (cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (holdReq) begin
        reqCount = '0; waitStates = WS_W'(ws + 3); autoAckEn = 1'b0;
        monEn = 1'b1; monTimeout = '0;
      end else begin
        reqValid = 1'b0;
      end
      if (xferStart) starts++;
      if (xferAck) acks++;
      if (accDone) begin
        err = accErr; cnt = int'(doneCount);
        reqValid = 1'b0;
        break;
      end
    end
  endtask

  // Externally acknowledged access; error placed on transfer errAt (-1: none)
  task automatic runExt(input int n, input int errAt, input bit alsoAck,
                        output int cyc, output int starts, output int err, output int cnt);
    bit pending;
    @(negedge clk);
    reqValid = 1'b1; reqCount = CNT_W'(n - 1); autoAckEn = 1'b0; monEn = 1'b0;
    cyc = 0; starts = 0; err = 0; cnt = 0; pending = 1'b0;
    while (cyc < 300) begin
      @(negedge clk);
      cyc++;
      reqValid = 1'b0; extAck = 1'b0; extErr = 1'b0;
      if (accDone) begin
        err = accErr; cnt = int'(doneCount);
        break;
      end
      if (pending) begin
        if (starts - 1 == errAt) begin
          extErr = 1'b1; extAck = alsoAck;
        end else begin
          extAck = 1'b1;
        end
        pending = 1'b0;
      end
      if (xferStart) begin
        starts++; pending = 1'b1;
      end
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc, starts, acks, err, cnt, expCyc;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!busy && !xferStart && !xferAck && !accDone && !accErr, "R10 reset outputs", int'(busy), 0);
    check(doneCount == 0, "R10 reset count", int'(doneCount), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R7: sweep wait states against monitor timeout and transfer count
    for (int n = 1; n <= 4; n++) begin
      for (int ws = 0; ws <= 5; ws++) begin
        for (int tmo = 0; tmo <= 5; tmo++) begin
          bit expErr;
          runAuto(n, ws, 1'b1, tmo, 1'b0, cyc, starts, acks, err, cnt);
          expErr = (ws > tmo);
          if (expErr) begin
            check(cyc == tmo + 3, "R7 monitor abort timing", cyc, tmo + 3);
            check(err == 1 && cnt == 0, "R7 monitor error count", cnt, 0);
            check(starts == 1, "R5 monitor skips rest", starts, 1);
          end else begin
            expCyc = n * (ws + 2) + (n - 1) + 1;
            check(cyc == expCyc, "R3 auto timing", cyc, expCyc);
            check(err == 0, "R7 ack wins or no timeout", err, 0);
            check(cnt == n && acks == n && starts == n, "R2 transfers", cnt, n);
          end
        end
      end
    end

    // R3: monitor disabled, long wait states
    runAuto(8, 15, 1'b0, 0, 1'b0, cyc, starts, acks, err, cnt);
    check(cyc == 8 * 17 + 8, "R3 max burst timing", cyc, 8 * 17 + 8);
    check(cnt == 8 && err == 0, "R9 max count", cnt, 8);

    // R9: count held while idle
    repeat (4) @(negedge clk);
    check(doneCount == 8, "R9 count held idle", int'(doneCount), 8);

    // R1: request held high and fields changed mid-access
    runAuto(3, 1, 1'b0, 0, 1'b1, cyc, starts, acks, err, cnt);
    check(cyc == 3 * 3 + 2 + 1, "R1 latched config timing", cyc, 12);
    check(cnt == 3 && err == 0 && starts == 3, "R1 latched count", cnt, 3);

    // R4 R5 R6: external ack, error on every position, with and without ack
    for (int n = 1; n <= 5; n++) begin
      runExt(n, -1, 1'b0, cyc, starts, err, cnt);
      check(cyc == 3 * n, "R4 ext ack timing", cyc, 3 * n);
      check(cnt == n && err == 0, "R4 ext ack count", cnt, n);
      for (int k = 0; k < n; k++) begin
        for (int both = 0; both <= 1; both++) begin
          runExt(n, k, both[0], cyc, starts, err, cnt);
          check(cyc == 3 * k + 3, both ? "R6 err with ack timing" : "R5 abort timing", cyc, 3 * k + 3);
          check(err == 1, "R8 error flag", err, 1);
          check(cnt == k, both ? "R6 err beats ack count" : "R5 abort count", cnt, k);
          check(starts == k + 1, "R5 no further starts", starts, k + 1);
        end
      end
    end

    // R8: done pulse lasts one cycle
    @(negedge clk);
    check(!accDone && !busy, "R8 done single pulse", int'(accDone), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule